// File: doc/BRIEF.md
# DSP Burst Local-Bus Arbiter

This block decides who drives a shared synchronous local bus: a bridge port or a DSP global-bus master. When idle, the bus belongs to the bridge. A DSP request is recognised when the DSP's active-low strobe is low and at least one of its four status lines is low. The arbiter then stops offering the bus to the bridge and waits for any bridge cycle in flight to end. After that it turns on the DSP's address and data drivers with two active-low enables.

During a DSP burst, the arbiter acknowledges each word with an active-low ready. The DSP samples ready on the next rising edge. Each acknowledged write word becomes a one-cycle push toward a downstream write FIFO, and the push carries the DSP data. If that FIFO reports full, ready is withheld until space returns. The DSP marks its final word by holding status bit 0 low. The grant ends on the edge where that word is acknowledged.

The DSP normally keeps the bus for its whole burst. There is one exception, to avoid deadlock: if the DSP is reading and the bridge asks for a read, the bridge takes the bus. When the bridge signals that its access is served, ownership returns to the DSP.

Top module: `dsp_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both enables and ready are high (inactive), no push occurs, and the bridge grant is high.
- R2: After a request is detected, the DSP enables stay high for as long as bridge_busy_i is high. They go low on the second rising edge after bridge_busy_i is seen low.
- R3: While either DSP enable is low, the bridge grant is low.
- R4: Ready goes low only while the DSP owns the bus and is requesting. The DSP's bus direction input is 1 for a read and 0 for a write.
- R5: Each write word acknowledged by ready produces push_o high for exactly that cycle, with push_data_o equal to the DSP data.
- R6: When a word with status bit 0 low is acknowledged, the enables go high on the next cycle. The bridge grant returns one cycle after that.
- R7: While fifo_full_i is high during a write burst, ready stays high and no push occurs. Ready returns in the second cycle after fifo_full_i falls.
- R8: A final-word marker that has not been acknowledged does not end the burst. The enables stay low until the marked word gets ready.
- R9: A bridge read request while the DSP is reading removes ready and, one cycle later, raises the bridge grant with the DSP enables high. One cycle after bridge_done_i, the DSP owns the bus again.
- R10: Read words never produce a push.
- R11: Outside the read-versus-read case, a bridge request during a DSP burst changes nothing. The grant stays low until the burst ends.
- R12: A low strobe with all status lines high, or status activity with the strobe high, is not a request. The bus stays with the bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dsp_strb_ni | input | 1 | DSP strobe, active low |
| dsp_stat_i | input | 4 | DSP status lines, all high = idle, bit 0 low = last word |
| dsp_rnw_i | input | 1 | DSP direction, 1 = read |
| dsp_data_i | input | 32 | DSP write data |
| fifo_full_i | input | 1 | Write FIFO full |
| brg_busy_i | input | 1 | Bridge local-bus cycle in progress |
| brg_req_i | input | 1 | Bridge wants the bus |
| brg_rd_i | input | 1 | Bridge request is a read |
| brg_done_i | input | 1 | Bridge preempting access finished |
| dsp_aen_no | output | 1 | DSP address driver enable, active low |
| dsp_den_no | output | 1 | DSP data driver enable, active low |
| dsp_rdy_no | output | 1 | Word acknowledge, active low |
| brg_gnt_o | output | 1 | Bus offered to bridge |
| push_o | output | 1 | One-cycle FIFO push |
| push_data_o | output | 32 | Data carried by the push |

## Verification
Two situations are hard to reach from the ports. The first is a final-word marker held while the FIFO is full. To reach it, the bench drives a write burst into ownership, raises fifo_full_i, and then presents the marked word, so the marker sits unacknowledged across several cycles before the FIFO drains. The second is deadlock preemption, which needs the DSP to be inside a read burst when a bridge read arrives. The bench reaches it by first walking the arbiter through request detection and the bridge wait, and only then raising the bridge read. It releases bridge_done_i while the DSP keeps its request up, to confirm that ownership comes back.

// File: rtl/dsp_arb_pkg.sv
package dsp_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BRG,
    ST_DSP_OWN,
    ST_DSP_HOLD,
    ST_BRG_PREEMPT,
    ST_RELEASE
  } arb_state_e;
endpackage

// File: rtl/dsp_req_detect.sv
module dsp_req_detect #(
  parameter int unsigned STAT_W   = 4,
  parameter int unsigned LAST_BIT = 0
) (
  input  logic              strb_ni,
  input  logic [STAT_W-1:0] stat_i,
  output logic              req_o,
  output logic              last_o
);
  localparam logic [STAT_W-1:0] IdleStat = '1;

  // any status line low plus strobe low marks an active word
  assign req_o  = !strb_ni && (stat_i != IdleStat);
  assign last_o = !stat_i[LAST_BIT];
endmodule

// File: rtl/dsp_arb_fsm.sv
module dsp_arb_fsm
  import dsp_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic last_i,
  input  logic rnw_i,
  input  logic fifo_full_i,
  input  logic brg_busy_i,
  input  logic brg_req_i,
  input  logic brg_rd_i,
  input  logic brg_done_i,
  output logic accept_o,
  output logic aen_no,
  output logic den_no,
  output logic rdy_no,
  output logic brg_gnt_o
);
  arb_state_e state_q, state_d;
  logic own, preempt, stall;

  assign own     = (state_q == ST_DSP_OWN);
  assign preempt = own && req_i && rnw_i && brg_req_i && brg_rd_i;
  assign stall   = own && req_i && !rnw_i && fifo_full_i;
  assign accept_o = own && req_i && !preempt && !stall;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (req_i) state_d = ST_WAIT_BRG;
      ST_WAIT_BRG:    if (!brg_busy_i) state_d = ST_DSP_OWN;
      ST_DSP_OWN: begin
        if (preempt)                 state_d = ST_BRG_PREEMPT;
        else if (stall)              state_d = ST_DSP_HOLD;
        else if (accept_o && last_i) state_d = ST_RELEASE;
      end
      ST_DSP_HOLD:    if (!fifo_full_i) state_d = ST_DSP_OWN;
      ST_BRG_PREEMPT: if (brg_done_i) state_d = ST_DSP_OWN;
      ST_RELEASE:     state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign aen_no    = !(own || state_q == ST_DSP_HOLD);
  assign den_no    = aen_no;
  assign rdy_no    = !accept_o;
  assign brg_gnt_o = (state_q == ST_IDLE) || (state_q == ST_BRG_PREEMPT);

  // R2
  wait_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_BRG && brg_busy_i) |=> state_q == ST_WAIT_BRG);
  // R2
  wait_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_BRG && !brg_busy_i) |=> state_q == ST_DSP_OWN);
  // R9
  preempt_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRG_PREEMPT && brg_done_i) |=> state_q == ST_DSP_OWN);
  // R8
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DSP_HOLD && fifo_full_i) |=> state_q == ST_DSP_HOLD);
endmodule

// File: rtl/dsp_push_gen.sv
module dsp_push_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              accept_i,
  input  logic              rnw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o
);
  assign push_o      = accept_i && !rnw_i;
  assign push_data_o = push_o ? data_i : '0;
endmodule

// File: rtl/dsp_bus_arbiter.sv
module dsp_bus_arbiter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dsp_strb_ni,
  input  logic [STAT_W-1:0] dsp_stat_i,
  input  logic              dsp_rnw_i,
  input  logic [DATA_W-1:0] dsp_data_i,
  input  logic              fifo_full_i,
  input  logic              brg_busy_i,
  input  logic              brg_req_i,
  input  logic              brg_rd_i,
  input  logic              brg_done_i,
  output logic              dsp_aen_no,
  output logic              dsp_den_no,
  output logic              dsp_rdy_no,
  output logic              brg_gnt_o,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o
);
  logic req, last, accept;

  dsp_req_detect #(.STAT_W(STAT_W), .LAST_BIT(0)) u_req (
    .strb_ni(dsp_strb_ni), .stat_i(dsp_stat_i), .req_o(req), .last_o(last)
  );

  dsp_arb_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .last_i(last),
    .rnw_i(dsp_rnw_i), .fifo_full_i(fifo_full_i), .brg_busy_i(brg_busy_i),
    .brg_req_i(brg_req_i), .brg_rd_i(brg_rd_i), .brg_done_i(brg_done_i),
    .accept_o(accept), .aen_no(dsp_aen_no), .den_no(dsp_den_no),
    .rdy_no(dsp_rdy_no), .brg_gnt_o(brg_gnt_o)
  );

  dsp_push_gen #(.DATA_W(DATA_W)) u_push (
    .accept_i(accept), .rnw_i(dsp_rnw_i), .data_i(dsp_data_i),
    .push_o(push_o), .push_data_o(push_data_o)
  );

  // R3
  excl_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dsp_aen_no |-> !brg_gnt_o);
  // R4
  rdy_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dsp_rdy_no |-> (!dsp_den_no && !dsp_strb_ni));
  // R6
  last_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dsp_rdy_no && !dsp_stat_i[0]) |=> dsp_aen_no);
  // R7
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !push_o);
  // R10
  no_push_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_rnw_i |-> !push_o);
endmodule

// File: tb/dsp_bus_arbiter_test.sv
module dsp_bus_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic strb_n = 1, rnw = 0, full = 0, busy = 0, breq = 0, brd = 0, bdone = 0;
  logic [3:0] stat = 4'hF;
  logic [31:0] data = 0;
  logic aen_n, den_n, rdy_n, gnt, push;
  logic [31:0] pdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dsp_bus_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .dsp_strb_ni(strb_n), .dsp_stat_i(stat),
    .dsp_rnw_i(rnw), .dsp_data_i(data), .fifo_full_i(full), .brg_busy_i(busy),
    .brg_req_i(breq), .brg_rd_i(brd), .brg_done_i(bdone),
    .dsp_aen_no(aen_n), .dsp_den_no(den_n), .dsp_rdy_no(rdy_n),
    .brg_gnt_o(gnt), .push_o(push), .push_data_o(pdata)
  );

  localparam logic [3:0] MID = 4'b1101, LAST = 4'b1100, IDL = 4'hF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic sn, input logic [3:0] st, input logic rw = 0,
                      input logic [31:0] d = 0, input logic f = 0, input logic bq = 0,
                      input logic br = 0, input logic bb = 0, input logic bd = 0);
    @(negedge clk);
    strb_n = sn; stat = st; rnw = rw; data = d; full = f;
    breq = bq; brd = br; busy = bb; bdone = bd;
    #2;
  endtask

  task automatic go_own(input logic rw);
    step(0, MID, rw);
    step(0, MID, rw);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 aen in reset", aen_n, 1); chk("R1 den in reset", den_n, 1);
    chk("R1 rdy in reset", rdy_n, 1); chk("R1 gnt in reset", gnt, 1);
    chk("R1 push in reset", push, 0);
    @(negedge clk); rst_n = 1;
    step(1, IDL);
    chk("R1 aen after reset", aen_n, 1); chk("R1 gnt after reset", gnt, 1);
  endtask

  task automatic t_write_burst;
    step(0, MID, 0, 32'hA0);
    chk("R2 aen idle detect", aen_n, 1); chk("R4 rdy idle", rdy_n, 1);
    step(0, MID, 0, 32'hA0);
    chk("R3 gnt off in wait", gnt, 0);
    step(0, MID, 0, 32'hA0);
    chk("R3 aen own", aen_n, 0); chk("R3 den own", den_n, 0);
    chk("R4 rdy own", rdy_n, 0); chk("R5 push w0", push, 1); chk("R5 data w0", pdata, 32'hA0);
    step(0, MID, 0, 32'hA1);
    chk("R5 push w1", push, 1); chk("R5 data w1", pdata, 32'hA1);
    step(0, LAST, 0, 32'hA2);
    chk("R5 data w2", pdata, 32'hA2); chk("R6 rdy last", rdy_n, 0);
    step(1, IDL);
    chk("R6 aen released", aen_n, 1); chk("R6 gnt not yet", gnt, 0);
    step(1, IDL);
    chk("R6 gnt back", gnt, 1);
  endtask

  task automatic t_bridge_wait;
    step(0, MID, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) begin
      step(0, MID, 0, 0, 0, 0, 0, 1);
      chk("R2 aen while busy", aen_n, 1);
    end
    step(0, MID, 0, 0, 0, 0, 0, 0);
    chk("R2 aen first idle cycle", aen_n, 1);
    step(0, MID, 0, 32'hB0);
    chk("R2 aen granted", aen_n, 0); chk("R2 rdy granted", rdy_n, 0);
    step(0, LAST, 0, 32'hB1);
    step(1, IDL); step(1, IDL);
  endtask

  task automatic t_fifo_full;
    go_own(0);
    step(0, MID, 0, 32'hC0, 1);
    chk("R7 rdy full", rdy_n, 1); chk("R7 push full", push, 0);
    step(0, MID, 0, 32'hC0, 1);
    chk("R7 rdy hold", rdy_n, 1); chk("R7 aen hold", aen_n, 0);
    step(0, MID, 0, 32'hC0, 0);
    chk("R7 rdy drain cycle", rdy_n, 1);
    step(0, MID, 0, 32'hC0, 0);
    chk("R7 rdy back", rdy_n, 0); chk("R7 data", pdata, 32'hC0);
    step(0, LAST, 0, 32'hC1, 1);
    chk("R8 rdy last full", rdy_n, 1);
    step(0, LAST, 0, 32'hC1, 1);
    chk("R8 aen kept", aen_n, 0);
    step(0, LAST, 0, 32'hC1, 0);
    chk("R8 aen kept drain", aen_n, 0);
    step(0, LAST, 0, 32'hC1, 0);
    chk("R8 last acked", rdy_n, 0); chk("R8 last pushed", pdata, 32'hC1);
    step(1, IDL);
    chk("R8 released", aen_n, 1);
    step(1, IDL);
  endtask

  task automatic t_deadlock;
    go_own(1);
    step(0, MID, 1, 32'hD0);
    chk("R4 read rdy", rdy_n, 0); chk("R10 read no push", push, 0);
    step(0, MID, 1, 0, 0, 1, 1);
    chk("R9 rdy withdrawn", rdy_n, 1);
    step(0, MID, 1, 0, 0, 1, 1);
    chk("R9 aen preempt", aen_n, 1); chk("R9 gnt preempt", gnt, 1);
    step(0, MID, 1, 0, 0, 0, 0, 0, 1);
    chk("R9 still bridge", gnt, 1);
    step(0, MID, 1);
    chk("R9 dsp back", aen_n, 0); chk("R9 rdy back", rdy_n, 0);
    step(0, LAST, 1);
    chk("R10 last read no push", push, 0);
    step(1, IDL); step(1, IDL);
  endtask

  task automatic t_no_preempt;
    go_own(1);
    step(0, MID, 1, 0, 0, 1, 0);
    chk("R11 write req no preempt rdy", rdy_n, 0); chk("R11 gnt low", gnt, 0);
    step(0, MID, 1, 0, 0, 1, 0);
    chk("R11 aen kept", aen_n, 0);
    go_own(0);
    step(0, LAST, 0, 32'hE0, 0, 1, 1);
    chk("R11 read req during write", rdy_n, 0); chk("R11 push", push, 1);
    step(1, IDL, 0, 0, 0, 1, 1);
    chk("R11 gnt low release", gnt, 0);
    step(1, IDL, 0, 0, 0, 1, 1);
    chk("R11 gnt after burst", gnt, 1);
    step(1, IDL);
  endtask

  task automatic t_no_request;
    for (int i = 0; i < 3; i++) begin
      step(0, IDL);
      chk("R12 strobe only aen", aen_n, 1); chk("R12 strobe only gnt", gnt, 1);
    end
    for (int i = 0; i < 3; i++) begin
      step(1, MID);
      chk("R12 status only aen", aen_n, 1); chk("R12 status only gnt", gnt, 1);
    end
  endtask

  initial begin
    t_reset();
    t_write_burst();
    t_bridge_wait();
    t_fifo_full();
    t_deadlock();
    t_no_preempt();
    t_write_burst();
    t_no_request();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule